// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the data-processing core of a small processor that runs a compact 16-bit instruction encoding. It is purely combinational. Two 32-bit operands, a 4-bit operation code and the current condition flags go in. Out come a 32-bit result, a register write strobe and the next value of the four condition flags. The flags are negative, zero, carry and overflow.

The operations fall into three flag classes. The first class is arithmetic: add, subtract, add with carry, subtract with carry, negate, compare and compare-negative. These rewrite all four flags. Carry after a subtraction means "no borrow". The second class is logical and multiply: AND, exclusive-OR, OR, bit-clear, invert-move, test and multiply. These rewrite only negative and zero, and pass carry and overflow through unchanged. The third class is the two high-register forms, add and move, which leave every flag untouched. A high-register compare is issued with the ordinary compare code, because it sets all four flags in the same way.

Compare, compare-negative and test exist only for their flags. For these the block still shows the computed value on the result port, but holds the write strobe low so the register file discards it. Shifts, memory access and register storage are handled by other blocks.

Top module: `flag_alu`

## Requirements
- R1: Operation code 0 (add) gives result = a + b modulo 2^32, sets C to the carry out of bit 31, and sets V when the signed sum overflows.
- R2: Operation codes 1 (subtract) and 5 (compare) give a − b. C is 1 exactly when a ≥ b as unsigned values. V is set on signed overflow of the difference.
- R3: Operation code 2 (add with carry) gives a + b + C_in. C is the carry out of the three-term sum and V is its signed overflow.
- R4: Operation code 3 (subtract with carry) gives a − b − (NOT C_in). C is 1 exactly when a ≥ b + (NOT C_in) as unsigned integers, and V is the signed overflow of that difference.
- R5: Operation code 4 (negate) gives 0 − b with subtraction flags, so C is 1 only when b is zero and V is set only for b = 0x80000000.
- R6: The write strobe is low for codes 5 (compare), 6 (compare-negative) and 7 (test), and high for every other code. Compare-negative sets all four flags exactly as an add of a and b would.
- R7: Codes 7 (test, a AND b), 8 (AND), 9 (exclusive-OR), 10 (OR), 11 (bit-clear, a AND NOT b) and 12 (invert-move, NOT b) produce their bitwise result, update N and Z from it, and copy C and V from the inputs.
- R8: Code 13 (multiply) gives the low 32 bits of a × b, updates N and Z from it, and copies C and V from the inputs.
- R9: Code 14 (high-register add) gives a + b and code 15 (high-register move) gives b. Both keep the write strobe high and pass all four flags through unchanged.
- R10: The flag vector is {N, Z, C, V} with N in bit 3 and V in bit 0. Wherever N and Z are updated, N is bit 31 of the result and Z is 1 exactly when the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code, values 0 to 15 as listed in the requirements |
| a_i | input | 32 | First operand (destination register value) |
| b_i | input | 32 | Second operand (source register value) |
| flags_i | input | 4 | Current flags {N, Z, C, V} |
| result_o | output | 32 | Computed value |
| wr_en_o | output | 1 | High when the result is to be written back |
| flags_o | output | 4 | Next flags {N, Z, C, V} |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle as its stimulus, with zero registers on the path. The bench changes the inputs on the falling clock edge and samples one time unit later, well before the next rising edge, so the logic has settled and no edge ordering is involved. The result, the write strobe and all four flags are compared on every vector. This applies to the directed carry, borrow and overflow corners and to seeded random operations drawn from a small set of extreme operand values mixed with arbitrary ones.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int OP_W   = 4;
    localparam int FLAG_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_ADC  = 4'h2,
        OP_SBC  = 4'h3,
        OP_NEG  = 4'h4,
        OP_CMP  = 4'h5,
        OP_CMN  = 4'h6,
        OP_TST  = 4'h7,
        OP_AND  = 4'h8,
        OP_EOR  = 4'h9,
        OP_ORR  = 4'hA,
        OP_BIC  = 4'hB,
        OP_MVN  = 4'hC,
        OP_MUL  = 4'hD,
        OP_ADDH = 4'hE,
        OP_MOVH = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        FCLS_ARITH,
        FCLS_NZ,
        FCLS_KEEP
    } flag_cls_e;

    typedef enum logic [1:0] {
        SRC_ADDER,
        SRC_LOGIC,
        SRC_MUL,
        SRC_PASS_B
    } res_src_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_b_i,
    input  logic         zero_a_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int SUM_W = W + 1;

    logic [W-1:0]     x;
    logic [W-1:0]     y;
    logic [SUM_W-1:0] full;

    always_comb begin
        x    = zero_a_i ? '0 : a_i;
        y    = inv_b_i ? ~b_i : b_i;
        full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin_i};
    end

    assign sum_o  = full[W-1:0];
    assign cout_o = full[W];
    assign ovf_o  = (x[W-1] == y[W-1]) && (sum_o[W-1] != x[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_EOR:  res_o = a_i ^ b_i;
            OP_ORR:  res_o = a_i | b_i;
            OP_BIC:  res_o = a_i & ~b_i;
            OP_MVN:  res_o = ~b_i;
            default: res_o = a_i & b_i;
        endcase
    end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prod_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] full;

    assign full   = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    assign prod_o = full[W-1:0];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   flags_i,
    output logic [W-1:0] result_o,
    output logic         wr_en_o,
    output logic [3:0]   flags_o
);
    alu_op_e   op;
    flags_t    fin;
    flags_t    fout;
    flag_cls_e fcls;
    res_src_e  src;
    logic      inv_b;
    logic      zero_a;
    logic      cin;
    logic      we;

    logic [W-1:0] sum;
    logic         cout;
    logic         ovf;
    logic [W-1:0] lres;
    logic [W-1:0] prod;

    assign op  = alu_op_e'(op_i);
    assign fin = flags_t'(flags_i);

    // operation decode: operand conditioning, result source, flag class
    always_comb begin
        inv_b  = 1'b0;
        zero_a = 1'b0;
        cin    = 1'b0;
        we     = 1'b1;
        src    = SRC_ADDER;
        fcls   = FCLS_ARITH;
        unique case (op)
            OP_ADD:  ;
            OP_SUB:  begin inv_b = 1'b1; cin = 1'b1; end
            OP_ADC:  cin = fin.c;
            OP_SBC:  begin inv_b = 1'b1; cin = fin.c; end
            OP_NEG:  begin inv_b = 1'b1; zero_a = 1'b1; cin = 1'b1; end
            OP_CMP:  begin inv_b = 1'b1; cin = 1'b1; we = 1'b0; end
            OP_CMN:  we = 1'b0;
            OP_TST:  begin src = SRC_LOGIC; fcls = FCLS_NZ; we = 1'b0; end
            OP_AND, OP_EOR, OP_ORR, OP_BIC, OP_MVN:
                     begin src = SRC_LOGIC; fcls = FCLS_NZ; end
            OP_MUL:  begin src = SRC_MUL; fcls = FCLS_NZ; end
            OP_ADDH: fcls = FCLS_KEEP;
            OP_MOVH: begin src = SRC_PASS_B; fcls = FCLS_KEEP; end
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .a_i      (a_i),
        .b_i      (b_i),
        .inv_b_i  (inv_b),
        .zero_a_i (zero_a),
        .cin_i    (cin),
        .sum_o    (sum),
        .cout_o   (cout),
        .ovf_o    (ovf)
    );

    alu_logic #(.W(W)) u_logic (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (lres)
    );

    alu_mul #(.W(W)) u_mul (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod)
    );

    always_comb begin
        unique case (src)
            SRC_ADDER:  result_o = sum;
            SRC_LOGIC:  result_o = lres;
            SRC_MUL:    result_o = prod;
            SRC_PASS_B: result_o = b_i;
        endcase
    end

    always_comb begin
        fout = fin;
        unique case (fcls)
            FCLS_ARITH: begin
                fout.n = result_o[W-1];
                fout.z = (result_o == '0);
                fout.c = cout;
                fout.v = ovf;
            end
            FCLS_NZ: begin
                fout.n = result_o[W-1];
                fout.z = (result_o == '0);
            end
            default: ;
        endcase
    end

    assign flags_o = fout;
    assign wr_en_o = we;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int W = 32
) (
    input logic [3:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [3:0]   flags_i,
    input logic [W-1:0] result_o,
    input logic         wr_en_o,
    input logic [3:0]   flags_o
);
    logic is_cmpfam;
    logic is_nzop;
    logic is_high;

    assign is_cmpfam = (op_i == 4'h5) || (op_i == 4'h6) || (op_i == 4'h7);
    assign is_nzop   = (op_i >= 4'h7) && (op_i <= 4'hD);
    assign is_high   = (op_i == 4'hE) || (op_i == 4'hF);

    always_comb begin
        AST_WE_COMPARE: assert (wr_en_o == !is_cmpfam); // R6
        if (op_i == 4'h0) begin
            AST_ADD_SUM: assert ({flags_o[1], result_o} == ({1'b0, a_i} + {1'b0, b_i})); // R1
        end
        if (op_i == 4'h1 || op_i == 4'h5) begin
            AST_SUB_NOBORROW: assert (flags_o[1] == (a_i >= b_i)); // R2
        end
        if (op_i == 4'h4) begin
            AST_NEG_CARRY: assert (flags_o[1] == (b_i == '0)); // R5
        end
        if (is_nzop) begin
            AST_LOGIC_HOLD_CV: assert (flags_o[1:0] == flags_i[1:0]); // R7
        end
        if (op_i == 4'hC) begin
            AST_MVN_INVERT: assert (result_o == ~b_i); // R7
        end
        if (is_high) begin
            AST_HIGH_HOLD_ALL: assert (flags_o == flags_i); // R9
        end
    end
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .flags_o  (flags_o)
);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [3:0]   fin;
    logic [W-1:0] res;
    logic         we;
    logic [3:0]   fout;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu #(.W(W)) dut (
        .op_i     (op),
        .a_i      (a),
        .b_i      (b),
        .flags_i  (fin),
        .result_o (res),
        .wr_en_o  (we),
        .flags_o  (fout)
    );

    typedef struct packed {
        logic [31:0] r;
        logic        w;
        logic [3:0]  f;
    } exp_t;

    function automatic logic ovf32(longint s);
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    function automatic exp_t model(logic [3:0] o, logic [31:0] x, logic [31:0] y, logic [3:0] fl);
        exp_t   e;
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint ux = longint'({32'h0, x});
        longint uy = longint'({32'h0, y});
        longint ci = longint'({63'h0, fl[1]});
        longint nci = 1 - ci;
        longint t;
        logic   c = 1'b0;
        logic   v = 1'b0;
        int     cls = 0; // 0 arith, 1 NZ only, 2 keep
        e.w = 1'b1;
        case (o)
            4'h0, 4'h6: begin t = ux + uy; e.r = t[31:0]; c = t > 64'hFFFFFFFF; v = ovf32(sx + sy); end
            4'h1, 4'h5: begin e.r = x - y; c = ux >= uy; v = ovf32(sx - sy); end
            4'h2: begin t = ux + uy + ci; e.r = t[31:0]; c = t > 64'hFFFFFFFF; v = ovf32(sx + sy + ci); end
            4'h3: begin t = ux - uy - nci; e.r = t[31:0]; c = ux >= uy + nci; v = ovf32(sx - sy - nci); end
            4'h4: begin e.r = 32'h0 - y; c = (y == 32'h0); v = ovf32(-sy); end
            4'h7, 4'h8: begin e.r = x & y; cls = 1; end
            4'h9: begin e.r = x ^ y; cls = 1; end
            4'hA: begin e.r = x | y; cls = 1; end
            4'hB: begin e.r = x & ~y; cls = 1; end
            4'hC: begin e.r = ~y; cls = 1; end
            4'hD: begin t = ux * uy; e.r = t[31:0]; cls = 1; end
            4'hE: begin t = ux + uy; e.r = t[31:0]; cls = 2; end
            default: begin e.r = y; cls = 2; end
        endcase
        if (o == 4'h5 || o == 4'h6 || o == 4'h7) e.w = 1'b0;
        if (cls == 0)      e.f = {e.r[31], e.r == 32'h0, c, v};
        else if (cls == 1) e.f = {e.r[31], e.r == 32'h0, fl[1], fl[0]};
        else               e.f = fl;
        return e;
    endfunction

    function automatic string tag_of(logic [3:0] o);
        case (o)
            4'h0: return "R1";
            4'h1, 4'h5: return "R2";
            4'h2: return "R3";
            4'h3: return "R4";
            4'h4: return "R5";
            4'h6: return "R6";
            4'hD: return "R8";
            4'hE, 4'hF: return "R9";
            default: return "R7";
        endcase
    endfunction

    task automatic run(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [3:0] fl, input string tag);
        exp_t e;
        @(negedge clk);
        op = o; a = x; b = y; fin = fl;
        #1;
        e = model(o, x, y, fl);
        n_checks++;
        if (res !== e.r || we !== e.w || fout !== e.f) begin
            n_fail++;
            $display("FAIL %s op=%h a=%h b=%h fin=%b: actual res=%h we=%b fl=%b expected res=%h we=%b fl=%b",
                     tag, o, x, y, fl, res, we, fout, e.r, e.w, e.f);
        end
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 6)
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'hFFFFFFFF;
            3: return 32'h7FFFFFFF;
            4: return 32'h80000000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        op = 4'h0; a = '0; b = '0; fin = 4'h0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle inputs: add of zeros
        run(4'h0, 32'h0, 32'h0, 4'h0, "R10 idle zero");
        // R1 carry and overflow corners
        run(4'h0, 32'hFFFFFFFF, 32'h1, 4'h0, "R1 carry wrap");
        run(4'h0, 32'h7FFFFFFF, 32'h1, 4'h0, "R1 signed ovf");
        // R2 subtraction borrow
        run(4'h1, 32'h5, 32'h5, 4'h0, "R2 equal");
        run(4'h1, 32'h3, 32'h5, 4'h2, "R2 borrow");
        run(4'h1, 32'h80000000, 32'h1, 4'h0, "R2 signed ovf");
        // R3 add with carry
        run(4'h2, 32'h1, 32'h1, 4'h2, "R3 cin1");
        run(4'h2, 32'hFFFFFFFF, 32'h0, 4'h2, "R3 carry via cin");
        // R4 subtract with carry
        run(4'h3, 32'h5, 32'h2, 4'h0, "R4 cin0");
        run(4'h3, 32'h5, 32'h2, 4'h2, "R4 cin1");
        run(4'h3, 32'h2, 32'h2, 4'h0, "R4 borrow");
        run(4'h3, 32'h7, 32'hFFFFFFFF, 4'h0, "R4 b max cin0");
        // R5 negate
        run(4'h4, 32'h1234, 32'h1, 4'h0, "R5 neg one");
        run(4'h4, 32'h1234, 32'h0, 4'h0, "R5 neg zero");
        run(4'h4, 32'h0, 32'h80000000, 4'h0, "R5 neg min");
        // R6 compare family, no write
        run(4'h5, 32'h9, 32'h9, 4'hF, "R6 cmp");
        run(4'h6, 32'hFFFFFFFF, 32'h1, 4'h0, "R6 cmn");
        run(4'h7, 32'hF0F0F0F0, 32'h0F0F0F0F, 4'h3, "R6 tst");
        // R7 logic ops keep C and V
        run(4'hB, 32'hFFFF00FF, 32'h000000F0, 4'h3, "R7 bic");
        run(4'hC, 32'h0, 32'h0, 4'h1, "R7 mvn");
        run(4'h9, 32'hA5A5A5A5, 32'hA5A5A5A5, 4'h2, "R7 eor zero");
        // R8 multiply
        run(4'hD, 32'h00010000, 32'h00010000, 4'h3, "R8 mul wrap");
        run(4'hD, 32'hFFFFFFFF, 32'h3, 4'h0, "R8 mul neg");
        // R9 high forms keep flags
        run(4'hE, 32'hFFFFFFFF, 32'h1, 4'h5, "R9 addh");
        run(4'hF, 32'h0, 32'h0, 4'hA, "R9 movh");
        // random sweep
        for (int i = 0; i < 800; i++) begin
            logic [3:0] ro;
            ro = 4'($urandom % 16);
            run(ro, pick(), pick(), 4'($urandom % 16), tag_of(ro));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule